// File: doc/BRIEF.md
# Nibble-Loaded Converter Code Register

This block is the digital front end of a 12-bit converter that sits on a narrow processor bus. The bus carries four data bits, a two-bit address, an active-low chip select and an active-low write strobe. A processor builds a code in three separate writes, each one filling a 4-bit staging register. It then writes to a fourth address, which copies all three staging registers into the output code register at once. That output register drives the converter. The transfer is atomic, so the converter never sees a code that is only partly updated, whatever order the nibbles were loaded in.

All strobes are sampled by the system clock and act on level. A selected register takes the data bus on every clock edge while chip select and write are both low, so it keeps the last value present before write is released. This matches a static-RAM write cycle. An active-low clear empties the output register at once, without waiting for a clock, and wins over any transfer. The staging registers are not touched by clear, so a later transfer brings back the code that was staged. There is no valid/ready handshake, because a bus write cannot be refused. The write strobe alone qualifies each transfer, and the block never applies back-pressure. Both register sets are visible as 12-bit ports.

Top module: `dacfe_top`

## Requirements
- R1: A write with address 0 (chip select and write both low) loads the data bus into staging bits 3..0 at the next clock edge.
- R2: Address 1 loads staging bits 7..4, and address 2 loads staging bits 11..8.
- R3: Writes to addresses 0, 1 and 2 leave the output code unchanged, in any order.
- R4: A write with address 3 copies the whole 12-bit staging value into the output code at one clock edge. The data bus is ignored and the staging value is left unchanged.
- R5: While chip select is high, neither the staging value nor the output code changes, whatever the write, address and data inputs are.
- R6: Driving clear low forces the output code to 0x000 at once, with no clock edge needed, and holds it there while clear stays low.
- R7: Clear takes priority over an address-3 transfer that is asserted at the same time.
- R8: Clear leaves the staging value unchanged, so a later address-3 transfer restores the staged code.
- R9: A selected register follows the data bus on every clock edge while its write is held low, and it keeps the last value sampled.
- R10: Reset drives the staging value and the output code to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe, level sensitive |
| bus_addr | input | 2 | 0 selects the low nibble, 1 the middle nibble, 2 the high nibble, 3 the transfer |
| bus_data | input | 4 | Nibble data bus |
| clr_n | input | 1 | Active-low asynchronous clear of the output code |
| code_q | output | 12 | Output code register that drives the converter |
| staged_q | output | 12 | Staging registers, high nibble in bits 11..8 |

## Verification
Each staging nibble appears on staged_q one clock after the write edge that samples it. A wrong write-enable therefore shows up as a misplaced or missing nibble on the very next sample. A transfer that fires when it should not, or that leaks into the code during staging, changes code_q while only staging writes are in progress, and this is visible one cycle later. A clear that is not asynchronous shows a nonzero code_q between the fall of clear and the next clock edge. A clear that disturbs staging shows as a wrong code_q after the restoring transfer.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int DEF_NIB_W   = 4;
  localparam int DEF_NUM_NIB = 3;

  // Address of the commit operation: one above the last nibble address.
  function automatic int commit_addr(input int num_nib);
    return num_nib;
  endfunction
endpackage

// File: rtl/dacfe_decode.sv
module dacfe_decode #(
  parameter int NUM_NIB = dacfe_pkg::DEF_NUM_NIB,
  parameter int ADDR_W  = $clog2(NUM_NIB + 1)
) (
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_NIB-1:0] nib_we,
  output logic              xfer_en
);
  localparam logic [ADDR_W-1:0] XFER_ADDR = ADDR_W'(dacfe_pkg::commit_addr(NUM_NIB));

  always_comb begin
    nib_we  = '0;
    xfer_en = 1'b0;
    if (!cs_n && !wr_n) begin
      if (addr == XFER_ADDR) xfer_en = 1'b1;
      for (int i = 0; i < NUM_NIB; i++) begin
        if (addr == ADDR_W'(i)) nib_we[i] = 1'b1;
      end
    end
  end

  // At most one target per bus cycle (R3: staging and commit never combine)
  always_comb begin
    assert_single_target_R3: assert ($onehot0({nib_we, xfer_en}));
  end
endmodule

// File: rtl/dacfe_stage.sv
module dacfe_stage #(
  parameter int NIB_W   = dacfe_pkg::DEF_NIB_W,
  parameter int NUM_NIB = dacfe_pkg::DEF_NUM_NIB
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_NIB-1:0]             nib_we,
  input  logic [NIB_W-1:0]               din,
  output logic [NUM_NIB-1:0][NIB_W-1:0]  nib_q
);
  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         nib_q[g] <= '0;
      else if (nib_we[g]) nib_q[g] <= din;
    end

    // R1/R2/R9: a selected nibble holds the bus value sampled at that edge
    assert_nib_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      nib_we[g] |=> nib_q[g] == $past(din));

    // R3: an unselected nibble keeps its value
    assert_nib_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !nib_we[g] |=> $stable(nib_q[g]));
  end
endmodule

// File: rtl/dacfe_outreg.sv
module dacfe_outreg #(
  parameter int CODE_W = dacfe_pkg::DEF_NIB_W * dacfe_pkg::DEF_NUM_NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              xfer_en,
  input  logic [CODE_W-1:0] staged,
  output logic [CODE_W-1:0] code_q
);
  logic arst_n;
  assign arst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      code_q <= '0;
    else if (xfer_en) code_q <= staged;
  end

  // R6: while clear is low the code reads zero
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code_q == '0);

  // R4: a commit copies the staged code in one edge
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && clr_n) |=> (!clr_n || code_q == $past(staged)));

  // R3: without commit or clear the code holds
  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && clr_n) |=> (!clr_n || $stable(code_q)));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
  parameter int NIB_W   = dacfe_pkg::DEF_NIB_W,
  parameter int NUM_NIB = dacfe_pkg::DEF_NUM_NIB,
  localparam int ADDR_W = $clog2(NUM_NIB + 1),
  localparam int CODE_W = NIB_W * NUM_NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_data,
  input  logic              clr_n,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] staged_q
);
  logic [NUM_NIB-1:0]            nib_we;
  logic                          xfer_en;
  logic [NUM_NIB-1:0][NIB_W-1:0] nib_q;

  dacfe_decode #(.NUM_NIB(NUM_NIB), .ADDR_W(ADDR_W)) u_dec (
    .cs_n(bus_cs_n), .wr_n(bus_wr_n), .addr(bus_addr),
    .nib_we(nib_we), .xfer_en(xfer_en)
  );

  dacfe_stage #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_stage (
    .clk(clk), .rst_n(rst_n), .nib_we(nib_we), .din(bus_data), .nib_q(nib_q)
  );

  assign staged_q = nib_q;

  dacfe_outreg #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .xfer_en(xfer_en),
    .staged(staged_q), .code_q(code_q)
  );

  // R5: a deselected bus changes nothing
  assert_deselect_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |=> $stable(staged_q));
  assert_deselect_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_n && clr_n) |=> (!clr_n || $stable(code_q)));
  // R8: clear never reaches the staging registers
  assert_clear_keeps_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && bus_cs_n) |=> $stable(staged_q));
endmodule

// File: tb/sim_dacfe_top.sv
`timescale 1ns/1ps
module sim_dacfe_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, clr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [3:0]  data = '0;
  logic [11:0] code_q, staged_q;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dacfe_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n),
    .bus_addr(addr), .bus_data(data), .clr_n(clr_n),
    .code_q(code_q), .staged_q(staged_q)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; data = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic t_reset;
    chk("R10 code after reset", code_q, 12'h000);
    chk("R10 staging after reset", staged_q, 12'h000);
  endtask

  task automatic t_stage_and_commit;
    bus_write(2'd2, 4'hA);
    chk("R3 code during staging", code_q, 12'h000);
    bus_write(2'd0, 4'h5);
    bus_write(2'd1, 4'hC);
    chk("R1 R2 staged nibbles", staged_q, 12'hAC5);
    chk("R3 code unchanged before commit", code_q, 12'h000);
    bus_write(2'd3, 4'hF);
    chk("R4 commit copies staging", code_q, 12'hAC5);
    chk("R4 commit ignores data bus", staged_q, 12'hAC5);
  endtask

  task automatic t_deselected;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0;
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); data = 4'(a + 1);
      @(negedge clk);
    end
    wr_n = 1'b1;
    chk("R5 staging held when deselected", staged_q, 12'hAC5);
    chk("R5 code held when deselected", code_q, 12'hAC5);
  endtask

  task automatic t_level_write;
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; data = 4'h1; wr_n = 1'b0;
    @(negedge clk);
    chk("R9 follows bus while held", staged_q, 12'hAC1);
    data = 4'h2;
    @(negedge clk); data = 4'h9;
    @(negedge clk); wr_n = 1'b1; data = 4'hF;
    @(negedge clk); cs_n = 1'b1;
    chk("R9 last value retained", staged_q, 12'hAC9);
    chk("R3 code unchanged by level write", code_q, 12'hAC5);
    bus_write(2'd3, 4'h0);
    chk("R4 commit after level write", code_q, 12'hAC9);
  endtask

  task automatic t_async_clear;
    @(negedge clk); #2 clr_n = 1'b0;
    #1 chk("R6 clear without clock edge", code_q, 12'h000);
    @(negedge clk);
    chk("R6 held while clear low", code_q, 12'h000);
    clr_n = 1'b1;
    @(negedge clk);
    chk("R8 clear keeps staging", staged_q, 12'hAC9);
    bus_write(2'd3, 4'h3);
    chk("R8 commit restores code", code_q, 12'hAC9);
  endtask

  task automatic t_clear_wins;
    bus_write(2'd1, 4'h7);
    @(negedge clk); cs_n = 1'b0; addr = 2'd3; wr_n = 1'b0; clr_n = 1'b0;
    @(negedge clk);
    chk("R7 clear beats commit", code_q, 12'h000);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R7 clear after commit", code_q, 12'h000);
    clr_n = 1'b1;
    @(negedge clk);
    chk("R7 code stays zero after clear release", code_q, 12'h000);
    chk("R8 staging intact after clear", staged_q, 12'hA79);
    bus_write(2'd3, 4'h0);
    chk("R8 commit after clear", code_q, 12'hA79);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_and_commit();
    t_deselected();
    t_level_write();
    t_async_clear();
    t_clear_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule